// File: doc/BRIEF.md
# Debug Module Access Controller with Sticky Status

This block sits behind the access chain of a debug transport. When the test access port signals an Update-DR on that chain, the block splits the shifted word into address, data and operation fields. It then either starts a read or write on the debug module bus or drops the request. While the access is in flight it tracks it and consumes the response. At Capture-DR it supplies the word to load back into the chain. That word holds the stored result (address, data and a status code) or, when an access is still pending, a busy code.

Two sticky flags record a busy collision and an error answer from the debug module. They stay set until the debugger updates the control/status chain with its clear bit high. A one-shot downgrade flag cancels exactly one update after a capture that returned an error. The block also supplies the control/status capture word, which carries a version, the address width and a summary of the sticky flags.

Top module: `dmi_xfer_ctrl`

## Requirements
- R1: Access chain layout is op in bits [1:0], data in [33:2] and address in [40:34] (address width 7). A non-busy capture returns the stored address and response data, with status 0 when the debug module answered 0 and status 2 when it answered any nonzero code.
- R2: Busy means (an access is outstanding and no response is valid in that cycle) or the sticky busy flag is set. A capture while busy returns status 3 and sets the sticky busy flag, so later captures also return 3 until it is cleared.
- R3: An update with op 1 (read) or op 2 (write) starts a request one cycle later, carrying the shifted address, data and op. Op 0 and op 3 start nothing.
- R4: An update starts no request while the block is busy. An update that finds an access outstanding also sets the sticky busy flag.
- R5: A non-busy capture of a nonzero stored status arms the downgrade flag. The next update is then cancelled and the flag is dropped, so the following update proceeds.
- R6: Request valid stays high with address, data and op unchanged until request ready is seen.
- R7: During a write, response ready follows response valid in the same cycle. During a read, response ready is low until the request handshake has completed.
- R8: A nonzero response sets a sticky error flag. The control/status status field reads 3 when sticky busy is set, otherwise 2 when sticky error is set, otherwise 0.
- R9: The sticky flags clear only on a control/status update with the clear bit high. An update with that bit low changes nothing.
- R10: The control/status capture word has version 1 in bits [3:0], the address width in bits [9:4], the status in bits [11:10], and zeros above.
- R11: After reset, no request or response ready is driven, the access capture word is all zero and the status field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dmi_upd_evt | input | 1 | Update-DR on the access chain |
| dmi_upd_word | input | 41 | Shifted access chain contents |
| dmi_cap_evt | input | 1 | Capture-DR on the access chain |
| dmi_cap_word | output | 41 | Value to load on capture |
| ctl_upd_evt | input | 1 | Update-DR on the control/status chain |
| ctl_clear_bit | input | 1 | Clear bit of the shifted control/status word |
| ctl_cap_word | output | 32 | Control/status capture value |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request ready |
| req_addr | output | 7 | Request address |
| req_data | output | 32 | Request write data |
| req_op | output | 2 | Request op (1 read, 2 write) |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response ready |
| rsp_data | input | 32 | Response data |
| rsp_op | input | 2 | Response status from the debug module |

## Verification
Each capture word and response ready is a combinational result, so the bench samples it one time step after raising the event, in the same cycle. Request valid and its fields come from a register, so they are checked one cycle after the update. Sticky flags and the downgrade flag are also registered. Their effect is checked through the next capture, the next update, or the control/status word read after the clock edge that follows the stimulus. All stimulus changes at the falling edge, so every sample falls half a period away from the edge that updates state.

// File: rtl/dmi_ctrl_pkg.sv
package dmi_ctrl_pkg;
   localparam logic [1:0] OP_NOP  = 2'd0;
   localparam logic [1:0] OP_RD   = 2'd1;
   localparam logic [1:0] OP_WR   = 2'd2;
   localparam logic [1:0] ST_OK   = 2'd0;
   localparam logic [1:0] ST_FAIL = 2'd2;
   localparam logic [1:0] ST_BUSY = 2'd3;
   localparam logic [3:0] CTL_VERSION = 4'd1;
   localparam int CTL_USED = 12;
endpackage

// File: rtl/dmi_word_codec.sv
module dmi_word_codec #(
   parameter int ABITS = 7,
   parameter int DBITS = 32,
   localparam int CW   = ABITS + DBITS + 2
) (
   input  logic [CW-1:0]    upd_word,
   output logic [ABITS-1:0] upd_addr,
   output logic [DBITS-1:0] upd_data,
   output logic [1:0]       upd_op,
   input  logic [ABITS-1:0] cap_addr,
   input  logic [DBITS-1:0] cap_data,
   input  logic [1:0]       cap_op,
   output logic [CW-1:0]    cap_word
);
   localparam int DLO = 2;
   localparam int ALO = DBITS + 2;

   always_comb begin
      upd_op   = upd_word[1:0];
      upd_data = upd_word[DLO +: DBITS];
      upd_addr = upd_word[ALO +: ABITS];
      cap_word = {cap_addr, cap_data, cap_op};
   end
endmodule

// File: rtl/dmi_req_tracker.sv
module dmi_req_tracker
   import dmi_ctrl_pkg::*;
#(
   parameter int ABITS = 7,
   parameter int DBITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ABITS-1:0] start_addr,
   input  logic [DBITS-1:0] start_data,
   input  logic [1:0]       start_op,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [ABITS-1:0] req_addr,
   output logic [DBITS-1:0] req_data,
   output logic [1:0]       req_op,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   output logic             rsp_fire,
   output logic             outstanding,
   output logic             wr_pending
);
   logic             valid_q;
   logic             pend_q;
   logic             is_wr_q;
   logic [ABITS-1:0] addr_q;
   logic [DBITS-1:0] data_q;
   logic [1:0]       op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
         is_wr_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         op_q    <= OP_NOP;
      end else begin
         if (start) begin
            valid_q <= 1'b1;
            addr_q  <= start_addr;
            data_q  <= start_data;
            op_q    <= start_op;
            is_wr_q <= (start_op == OP_WR);
         end else if (valid_q && req_ready) begin
            valid_q <= 1'b0;
         end
         if (start)         pend_q <= 1'b1;
         else if (rsp_fire) pend_q <= 1'b0;
      end
   end

   always_comb begin
      req_valid   = valid_q;
      req_addr    = addr_q;
      req_data    = data_q;
      req_op      = op_q;
      rsp_ready   = pend_q && (is_wr_q ? rsp_valid : !valid_q);
      rsp_fire    = rsp_valid && rsp_ready;
      outstanding = pend_q;
      wr_pending  = pend_q && is_wr_q;
   end
endmodule

// File: rtl/dmi_sticky_status.sv
module dmi_sticky_status
   import dmi_ctrl_pkg::*;
#(
   parameter int ABITS = 7,
   parameter int DBITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_evt,
   input  logic             upd_evt,
   input  logic             clear_evt,
   input  logic             outstanding,
   input  logic             rsp_valid,
   input  logic             rsp_fire,
   input  logic [1:0]       rsp_op,
   input  logic [DBITS-1:0] rsp_data,
   input  logic             start,
   input  logic [ABITS-1:0] start_addr,
   output logic             busy,
   output logic             sticky_busy,
   output logic             sticky_err,
   output logic             downgrade,
   output logic [ABITS-1:0] cap_addr,
   output logic [DBITS-1:0] cap_data,
   output logic [1:0]       cap_op,
   output logic [1:0]       ctl_stat
);
   logic             sbusy_q;
   logic             serr_q;
   logic             dg_q;
   logic [ABITS-1:0] st_addr_q;
   logic [DBITS-1:0] st_data_q;
   logic [1:0]       st_op_q;

   assign busy = (outstanding && !rsp_valid) || sbusy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sbusy_q   <= 1'b0;
         serr_q    <= 1'b0;
         dg_q      <= 1'b0;
         st_addr_q <= '0;
         st_data_q <= '0;
         st_op_q   <= ST_OK;
      end else begin
         if (clear_evt)                         sbusy_q <= 1'b0;
         else if ((cap_evt || upd_evt) && busy) sbusy_q <= 1'b1;

         if (clear_evt)                         serr_q <= 1'b0;
         else if (rsp_fire && rsp_op != 2'd0)   serr_q <= 1'b1;

         if (cap_evt)      dg_q <= !busy && (st_op_q != ST_OK);
         else if (upd_evt) dg_q <= 1'b0;

         if (start) st_addr_q <= start_addr;
         if (rsp_fire) begin
            st_data_q <= rsp_data;
            st_op_q   <= (rsp_op == 2'd0) ? ST_OK : ST_FAIL;
         end
      end
   end

   always_comb begin
      sticky_busy = sbusy_q;
      sticky_err  = serr_q;
      downgrade   = dg_q;
      cap_addr    = st_addr_q;
      cap_data    = st_data_q;
      cap_op      = busy ? ST_BUSY : st_op_q;
      if (sbusy_q)     ctl_stat = ST_BUSY;
      else if (serr_q) ctl_stat = ST_FAIL;
      else             ctl_stat = ST_OK;
   end
endmodule

// File: rtl/dmi_xfer_ctrl.sv
module dmi_xfer_ctrl
   import dmi_ctrl_pkg::*;
#(
   parameter int ABITS = 7,
   parameter int DBITS = 32,
   parameter int CTL_W = 32,
   localparam int CW   = ABITS + DBITS + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dmi_upd_evt,
   input  logic [CW-1:0]    dmi_upd_word,
   input  logic             dmi_cap_evt,
   output logic [CW-1:0]    dmi_cap_word,
   input  logic             ctl_upd_evt,
   input  logic             ctl_clear_bit,
   output logic [CTL_W-1:0] ctl_cap_word,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [ABITS-1:0] req_addr,
   output logic [DBITS-1:0] req_data,
   output logic [1:0]       req_op,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   input  logic [DBITS-1:0] rsp_data,
   input  logic [1:0]       rsp_op
);
   generate
      if (ABITS < 1 || ABITS > 63) begin : g_bad_abits
         $error("ABITS must lie in 1..63");
      end
      if (DBITS < 1) begin : g_bad_dbits
         $error("DBITS must be positive");
      end
      if (CTL_W < CTL_USED) begin : g_bad_ctlw
         $error("CTL_W too narrow for the status layout");
      end
   endgenerate

   logic [ABITS-1:0] u_addr;
   logic [DBITS-1:0] u_data;
   logic [1:0]       u_op;
   logic [ABITS-1:0] c_addr;
   logic [DBITS-1:0] c_data;
   logic [1:0]       c_op;
   logic [1:0]       stat_w;
   logic             busy_w;
   logic             sticky_busy_w;
   logic             sticky_err_w;
   logic             downgrade_w;
   logic             outstanding_w;
   logic             wr_pending_w;
   logic             rsp_fire_w;
   logic             accept_w;
   logic             clear_w;
   logic             real_op_w;

   dmi_word_codec #(.ABITS(ABITS), .DBITS(DBITS)) u_codec (
      .upd_word (dmi_upd_word),
      .upd_addr (u_addr),
      .upd_data (u_data),
      .upd_op   (u_op),
      .cap_addr (c_addr),
      .cap_data (c_data),
      .cap_op   (c_op),
      .cap_word (dmi_cap_word)
   );

   always_comb begin
      real_op_w = (u_op == OP_RD) || (u_op == OP_WR);
      accept_w  = dmi_upd_evt && real_op_w && !busy_w && !downgrade_w &&
                  (!outstanding_w || rsp_fire_w);
      clear_w   = ctl_upd_evt && ctl_clear_bit;
   end

   dmi_req_tracker #(.ABITS(ABITS), .DBITS(DBITS)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept_w),
      .start_addr  (u_addr),
      .start_data  (u_data),
      .start_op    (u_op),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .req_data    (req_data),
      .req_op      (req_op),
      .rsp_valid   (rsp_valid),
      .rsp_ready   (rsp_ready),
      .rsp_fire    (rsp_fire_w),
      .outstanding (outstanding_w),
      .wr_pending  (wr_pending_w)
   );

   dmi_sticky_status #(.ABITS(ABITS), .DBITS(DBITS)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_evt     (dmi_cap_evt),
      .upd_evt     (dmi_upd_evt),
      .clear_evt   (clear_w),
      .outstanding (outstanding_w),
      .rsp_valid   (rsp_valid),
      .rsp_fire    (rsp_fire_w),
      .rsp_op      (rsp_op),
      .rsp_data    (rsp_data),
      .start       (accept_w),
      .start_addr  (u_addr),
      .busy        (busy_w),
      .sticky_busy (sticky_busy_w),
      .sticky_err  (sticky_err_w),
      .downgrade   (downgrade_w),
      .cap_addr    (c_addr),
      .cap_data    (c_data),
      .cap_op      (c_op),
      .ctl_stat    (stat_w)
   );

   localparam logic [5:0] ABITS_FIELD = 6'(ABITS);

   generate
      if (CTL_W > CTL_USED) begin : g_ctl_pad
         assign ctl_cap_word = {{(CTL_W-CTL_USED){1'b0}}, stat_w, ABITS_FIELD, CTL_VERSION};
      end else begin : g_ctl_exact
         assign ctl_cap_word = {stat_w, ABITS_FIELD, CTL_VERSION};
      end
   endgenerate
endmodule

// File: rtl/dmi_xfer_ctrl_chk.sv
module dmi_xfer_ctrl_chk #(
   parameter int ABITS = 7,
   parameter int DBITS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dmi_upd_evt,
   input logic             dmi_cap_evt,
   input logic             ctl_upd_evt,
   input logic             ctl_clear_bit,
   input logic             req_valid,
   input logic             req_ready,
   input logic [ABITS-1:0] req_addr,
   input logic [DBITS-1:0] req_data,
   input logic [1:0]       req_op,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic             busy,
   input logic             sticky_busy,
   input logic             sticky_err,
   input logic             downgrade,
   input logic             wr_pending
);
   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                     $stable(req_data) && $stable(req_op)));

   assert_busy_capture_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dmi_cap_evt && busy) |=> sticky_busy);

   assert_sticky_blocks_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dmi_upd_evt && sticky_busy) |=> !$rose(req_valid));

   assert_downgrade_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dmi_upd_evt && downgrade && !dmi_cap_evt) |=> (!$rose(req_valid) && !downgrade));

   assert_write_rsp_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && wr_pending) |-> rsp_ready);

   assert_err_clear_only_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sticky_err) |-> $past(ctl_upd_evt && ctl_clear_bit));

   assert_busy_clear_only_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sticky_busy) |-> $past(ctl_upd_evt && ctl_clear_bit));
endmodule

bind dmi_xfer_ctrl dmi_xfer_ctrl_chk #(.ABITS(ABITS), .DBITS(DBITS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dmi_upd_evt   (dmi_upd_evt),
   .dmi_cap_evt   (dmi_cap_evt),
   .ctl_upd_evt   (ctl_upd_evt),
   .ctl_clear_bit (ctl_clear_bit),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_data      (req_data),
   .req_op        (req_op),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .busy          (busy_w),
   .sticky_busy   (sticky_busy_w),
   .sticky_err    (sticky_err_w),
   .downgrade     (downgrade_w),
   .wr_pending    (wr_pending_w)
);

// File: tb/dmi_xfer_ctrl_tb.sv
module dmi_xfer_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AB = 7;
   localparam int DB = 32;
   localparam int CW = AB + DB + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dmi_upd_evt = 1'b0;
   logic [CW-1:0] dmi_upd_word = '0;
   logic          dmi_cap_evt = 1'b0;
   logic [CW-1:0] dmi_cap_word;
   logic          ctl_upd_evt = 1'b0;
   logic          ctl_clear_bit = 1'b0;
   logic [31:0]   ctl_cap_word;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [AB-1:0] req_addr;
   logic [DB-1:0] req_data;
   logic [1:0]    req_op;
   logic          rsp_valid = 1'b0;
   logic          rsp_ready;
   logic [DB-1:0] rsp_data = '0;
   logic [1:0]    rsp_op = '0;

   int vectors = 0;
   int fails = 0;

   logic [AB-1:0] exp_addr = '0;
   logic [DB-1:0] exp_data = '0;
   logic [1:0]    exp_st = 2'd0;
   logic [CW-1:0] cap_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmi_xfer_ctrl u_dut (
      .clk (clk), .rst_n (rst_n),
      .dmi_upd_evt (dmi_upd_evt), .dmi_upd_word (dmi_upd_word),
      .dmi_cap_evt (dmi_cap_evt), .dmi_cap_word (dmi_cap_word),
      .ctl_upd_evt (ctl_upd_evt), .ctl_clear_bit (ctl_clear_bit),
      .ctl_cap_word (ctl_cap_word),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_data (req_data), .req_op (req_op),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
      .rsp_data (rsp_data), .rsp_op (rsp_op)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl_exp(input logic [1:0] st);
      return {20'd0, st, 6'd7, 4'd1};
   endfunction

   task automatic upd(input logic [AB-1:0] a, input logic [DB-1:0] d, input logic [1:0] op);
      @(negedge clk);
      dmi_upd_evt  = 1'b1;
      dmi_upd_word = {a, d, op};
      @(negedge clk);
      dmi_upd_evt  = 1'b0;
   endtask

   task automatic cap();
      @(negedge clk);
      dmi_cap_evt = 1'b1;
      #1 cap_val = dmi_cap_word;
      @(negedge clk);
      dmi_cap_evt = 1'b0;
   endtask

   task automatic ctl(input logic clr);
      @(negedge clk);
      ctl_upd_evt   = 1'b1;
      ctl_clear_bit = clr;
      @(negedge clk);
      ctl_upd_evt   = 1'b0;
      ctl_clear_bit = 1'b0;
   endtask

   task automatic acc(input logic [AB-1:0] a, input logic [DB-1:0] d, input logic [1:0] op,
                      input int rw, input int rsw, input logic [1:0] code, input bit issue);
      upd(a, d, op);
      if (!issue) begin
         chk("R4/R5 no request", 64'(req_valid), 64'd0);
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4/R5 request stays idle", 64'(req_valid), 64'd0);
         end
         return;
      end
      chk("R3 request valid", 64'(req_valid), 64'd1);
      chk("R3 request fields", 64'({req_addr, req_data, req_op}), 64'({a, d, op}));
      for (int i = 0; i < rw; i++) begin
         if (op == 2'd1) chk("R7 read ready held low", 64'(rsp_ready), 64'd0);
         @(negedge clk);
         chk("R6 request held", 64'({req_valid, req_addr, req_data, req_op}), 64'({1'b1, a, d, op}));
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk("R6 request drops after handshake", 64'(req_valid), 64'd0);
      if (op == 2'd1) chk("R7 read ready after request", 64'(rsp_ready), 64'd1);
      else            chk("R7 write ready idle", 64'(rsp_ready), 64'd0);
      for (int i = 0; i < rsw; i++) @(negedge clk);
      rsp_valid = 1'b1;
      rsp_op    = code;
      rsp_data  = d ^ 32'h5A5A_5A5A;
      #1 chk("R7 response ready", 64'(rsp_ready), 64'd1);
      @(negedge clk);
      rsp_valid = 1'b0;
      exp_addr = a;
      exp_data = d ^ 32'h5A5A_5A5A;
      exp_st   = (code == 2'd0) ? 2'd0 : 2'd2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 request idle", 64'(req_valid), 64'd0);
      chk("R11 response ready idle", 64'(rsp_ready), 64'd0);
      chk("R11 capture word", 64'(dmi_cap_word), 64'd0);
      chk("R10 R11 control word", 64'(ctl_cap_word), 64'(ctl_exp(2'd0)));

      // sweep of clean reads and writes
      for (int i = 0; i < 24; i++) begin
         logic [AB-1:0] a;
         logic [DB-1:0] d;
         a = AB'((i * 37) % 128);
         d = (32'h0101_0101 * i) ^ 32'h1234_5678;
         acc(a, d, (i % 2) ? 2'd2 : 2'd1, i % 3, (i / 3) % 3, 2'd0, 1'b1);
         cap();
         chk("R1 capture result", 64'(cap_val), 64'({exp_addr, exp_data, exp_st}));
      end
      acc(7'h7F, 32'hFFFF_FFFF, 2'd2, 0, 0, 2'd0, 1'b1);
      cap();
      chk("R1 capture top address", 64'(cap_val), 64'({exp_addr, exp_data, exp_st}));

      // no-op codes
      acc(7'h11, 32'hDEAD_0000, 2'd0, 0, 0, 2'd0, 1'b0);
      acc(7'h12, 32'hDEAD_0001, 2'd3, 0, 0, 2'd0, 1'b0);
      cap();
      chk("R3 no-op leaves capture", 64'(cap_val), 64'({exp_addr, exp_data, exp_st}));

      // error response and downgrade
      acc(7'h21, 32'hCAFE_0001, 2'd1, 1, 1, 2'd2, 1'b1);
      chk("R8 error status", 64'(ctl_cap_word), 64'(ctl_exp(2'd2)));
      cap();
      chk("R1 failed status", 64'(cap_val), 64'({exp_addr, exp_data, 2'd2}));
      acc(7'h22, 32'hCAFE_0002, 2'd2, 0, 0, 2'd0, 1'b0);
      acc(7'h23, 32'hCAFE_0003, 2'd2, 0, 1, 2'd0, 1'b1);
      cap();
      chk("R5 second update proceeds", 64'(cap_val), 64'({exp_addr, exp_data, 2'd0}));
      chk("R8 error still sticky", 64'(ctl_cap_word), 64'(ctl_exp(2'd2)));
      acc(7'h24, 32'hCAFE_0004, 2'd1, 0, 0, 2'd3, 1'b1);
      cap();
      chk("R1 code 3 maps to failed", 64'(cap_val[1:0]), 64'd2);
      acc(7'h25, 32'hCAFE_0005, 2'd1, 0, 0, 2'd0, 1'b0);
      ctl(1'b0);
      chk("R9 clear bit low ignored", 64'(ctl_cap_word), 64'(ctl_exp(2'd2)));
      ctl(1'b1);
      chk("R9 error cleared", 64'(ctl_cap_word), 64'(ctl_exp(2'd0)));

      // busy capture
      upd(7'h31, 32'h0BAD_F00D, 2'd1);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      cap();
      chk("R2 busy capture", 64'(cap_val[1:0]), 64'd3);
      chk("R8 busy status", 64'(ctl_cap_word), 64'(ctl_exp(2'd3)));
      acc(7'h32, 32'h1111_2222, 2'd2, 0, 0, 2'd0, 1'b0);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_op = 2'd0; rsp_data = 32'h7777_8888;
      #1 chk("R7 read response taken", 64'(rsp_ready), 64'd1);
      @(negedge clk);
      rsp_valid = 1'b0;
      cap();
      chk("R2 busy sticks", 64'(cap_val[1:0]), 64'd3);
      ctl(1'b1);
      chk("R9 busy cleared", 64'(ctl_cap_word), 64'(ctl_exp(2'd0)));
      cap();
      chk("R1 late read result", 64'(cap_val), 64'({7'h31, 32'h7777_8888, 2'd0}));

      // update while outstanding
      upd(7'h41, 32'h4141_4141, 2'd2);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      acc(7'h42, 32'h4242_4242, 2'd1, 0, 0, 2'd0, 1'b0);
      chk("R4 update while outstanding sets busy", 64'(ctl_cap_word), 64'(ctl_exp(2'd3)));
      @(negedge clk);
      rsp_valid = 1'b1; rsp_op = 2'd0; rsp_data = 32'h0;
      #1 chk("R7 write ready follows valid", 64'(rsp_ready), 64'd1);
      @(negedge clk);
      rsp_valid = 1'b0;
      ctl(1'b1);
      acc(7'h43, 32'h4343_4343, 2'd1, 0, 0, 2'd0, 1'b1);
      cap();
      chk("R4 resumes after clear", 64'(cap_val), 64'({exp_addr, exp_data, 2'd0}));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule